// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block supervises a processor through one shared active-low line that it can only pull down. The line carries the processor reset and also serves as the processor's watchdog input. An external comparator reports whether the supply is good. The pad logic gives two sampled views of the line: one is true when the line is below the strobe level, and the other is true when it is below the logic-low level. The block's only drive is a pull-low enable for that line. A status flag reports whether the current reset pulse came from a watchdog timeout.

A bad supply holds the line low with no clock delay. Once the supply turns good, the hold continues for a fixed hold-off time. After that the processor must pull the line through the strobe level at regular intervals. If it stops, the block emits fixed-length reset pulses, one per timeout period, until strobing resumes. Any source wired onto the line can also pull it below logic-low long enough to pass the debounce. Such a low is taken as an override and stretched to a full reset pulse.

All durations are parameters counted in clock cycles: `RST_CYCLES`, `WDT_CYCLES`, `DEB_CYCLES` and `STB_MIN_CYCLES`. Both line views pass through a two-stage synchroniser before any detection logic sees them.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_ok_i` is 0, `pull_low_o` is 1 in the same cycle, without waiting for a clock edge.
- R2: After `supply_ok_i` rises and stays 1, `pull_low_o` remains 1 for exactly `RST_CYCLES` cycles, counted from the first edge that samples the good supply, and then drops to 0.
- R3: A supply drop of even one sampled cycle during the hold-off restarts the full `RST_CYCLES` count from the next rise.
- R4: With no strobe, `pull_low_o` rises exactly `WDT_CYCLES` cycles after the line was released. The resulting pulse lasts exactly `RST_CYCLES` cycles.
- R5: While strobes stay absent, pulses repeat: each release is followed by another `WDT_CYCLES` low-free interval and then another pulse.
- R6: A below-strobe low seen for at least `STB_MIN_CYCLES` consecutive samples, after the line was high, is a strobe. It restarts the watchdog count at the edge `STB_MIN_CYCLES + 2` cycles after its first sampled low.
- R7: A below-strobe low shorter than `STB_MIN_CYCLES` samples has no effect on when the next watchdog pulse starts.
- R8: A below-logic low held for `DEB_CYCLES` samples is an override. `pull_low_o` rises `DEB_CYCLES + 2` cycles after its first sampled low, and the pulse lasts `RST_CYCLES` cycles.
- R9: A below-logic low shorter than `DEB_CYCLES` samples does not cause an override pulse.
- R10: The block's own low on the line is never taken as a strobe or an override. A pulse is followed by a full `WDT_CYCLES` interval and not by a self-triggered pulse.
- R11: A supply failure during a reset pulse moves the block to the supply hold. The status clears, and the next release needs a full `RST_CYCLES` hold-off.
- R12: `wd_trip_o` is 1 throughout a pulse caused by a watchdog timeout. It is 0 during override pulses, during the supply hold and while the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| supply_ok_i | input | 1 | Supply within tolerance, from external comparator |
| pin_below_strobe_i | input | 1 | Line is below the strobe level (asynchronous) |
| pin_below_logic_i | input | 1 | Line is below the logic-low level (asynchronous) |
| pull_low_o | output | 1 | Enable for the open-drain pull-down of the line |
| wd_trip_o | output | 1 | Current reset pulse was caused by a watchdog timeout |

## Verification
The hardest case to reach from the ports is an external low that falls between the two acceptance widths. Such a low is long enough to count as a strobe but too short to pass the override debounce, so it must push the watchdog pulse back rather than trigger a reset. The stimulus table places lows of chosen widths on each line view at a fixed offset after every release. Each row predicts either the bare timeout, the timeout shifted by the strobe latency, or the override latency. The bench models the wired line, so the block's own pulses reach its inputs, and each row also confirms that the release after a pulse produces no self-triggered reset.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PULSE = 2'd2
  } sup_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sup_strobe_filt.sv
module sup_strobe_filt #(
  parameter int unsigned MIN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_i,
  input  logic mask_i,
  output logic hit_o
);

  localparam int unsigned LW = $clog2(MIN_CYC + 1);
  localparam logic [LW-1:0] LAST = LW'(MIN_CYC - 1);

  logic          armed_q, armed_n;
  logic [LW-1:0] cnt_q, cnt_n;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign hit_o   = !mask_i && below_i && armed_q && at_last;

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    if (mask_i) begin
      armed_n = 1'b0;
      cnt_n   = '0;
    end else if (!below_i) begin
      armed_n = 1'b1;
      cnt_n   = '0;
    end else if (armed_q) begin
      if (at_last) begin
        armed_n = 1'b0;
        cnt_n   = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
    end
  end

  // R6: one accepted strobe per low excursion
  p_single_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);

  // R7: the low counter never runs past its acceptance point
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/sup_override_deb.sv
module sup_override_deb #(
  parameter int unsigned DEB_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_i,
  input  logic mask_i,
  output logic acc_o
);

  localparam int unsigned DW = $clog2(DEB_CYC + 1);
  localparam logic [DW-1:0] LAST = DW'(DEB_CYC - 1);

  logic [DW-1:0] cnt_q, cnt_n;
  logic          cnt_en;
  logic          stable_low;

  assign stable_low = below_i && !mask_i;
  assign acc_o      = stable_low && (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (!stable_low) begin
      cnt_en = (cnt_q != '0);
      cnt_n  = '0;
    end else if (cnt_q != LAST) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  if (DEB_CYC > 1) begin : g_deb_chk
    // R9: an override needs the low to have been present the cycle before
    p_deb_needs_history_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_o |-> $past(below_i && !mask_i));
  end

  // R8: the debounce counter saturates at its acceptance point
  p_deb_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import sup_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 20,
  parameter int unsigned WDT_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic strobe_hit_i,
  input  logic ovr_hit_i,
  output logic pull_low_o,
  output logic wd_trip_o
);

  localparam int unsigned CNT_MAX = max_u(RST_CYCLES, WDT_CYCLES);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYCLES - 1);
  localparam logic [CNT_W-1:0] WDT_LAST = CNT_W'(WDT_CYCLES - 1);

  sup_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cause_q, cause_n;
  logic             cnt_en;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    cause_n = cause_q;
    if (!supply_ok_i) begin
      state_n = ST_HOLD;
      cnt_n   = '0;
      cause_n = 1'b0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (cnt_q == RST_LAST) begin
            state_n = ST_RUN;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (ovr_hit_i) begin
            state_n = ST_PULSE;
            cnt_n   = '0;
            cause_n = 1'b0;
          end else if (strobe_hit_i) begin
            cnt_n = '0;
          end else if (cnt_q == WDT_LAST) begin
            state_n = ST_PULSE;
            cnt_n   = '0;
            cause_n = 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_PULSE: begin
          if (cnt_q == RST_LAST) begin
            state_n = ST_RUN;
            cnt_n   = '0;
            cause_n = 1'b0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: begin
          state_n = ST_HOLD;
          cnt_n   = '0;
          cause_n = 1'b0;
        end
      endcase
    end
  end

  assign cnt_en = (cnt_n != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      cause_q <= 1'b0;
    end else begin
      state_q <= state_n;
      cause_q <= cause_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign pull_low_o = !supply_ok_i || (state_q != ST_RUN);
  assign wd_trip_o  = cause_q;

  // R1: a bad supply always lands in the hold state with a cleared count
  p_brownout_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> (state_q == ST_HOLD) && (cnt_q == '0));

  // R2: leaving the hold only after the full hold-off count
  p_hold_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) == ST_HOLD) |-> ($past(cnt_q) == RST_LAST));

  // R4: a watchdog pulse starts only after the full timeout
  p_wd_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PULSE && $past(state_q) == ST_RUN && wd_trip_o)
      |-> ($past(cnt_q) == WDT_LAST));

  // R5: run and pulse counts stay within their windows
  p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (cnt_q <= WDT_LAST));
  p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |-> (cnt_q <= RST_LAST));

  // R6: an accepted strobe restarts the watchdog count
  p_strobe_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && strobe_hit_i && !ovr_hit_i) |=> (cnt_q == '0));

  // R12: the status flag only accompanies a pulse
  p_status_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wd_trip_o |-> (state_q == ST_PULSE));

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned RST_CYCLES     = 125_000_000,
  parameter int unsigned WDT_CYCLES     = 175_000_000,
  parameter int unsigned DEB_CYCLES     = 2_500_000,
  parameter int unsigned STB_MIN_CYCLES = 125,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic pin_below_strobe_i,
  input  logic pin_below_logic_i,
  output logic pull_low_o,
  output logic wd_trip_o
);

  localparam int unsigned BLANK = SYNC_STAGES + 1;

  logic [1:0]       pin_sync;
  logic [BLANK-1:0] blank_q;
  logic             mask;
  logic             strobe_hit;
  logic             ovr_hit;

  sup_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({pin_below_logic_i, pin_below_strobe_i}),
    .sync_o  (pin_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blank_q <= '1;
    else        blank_q <= {blank_q[BLANK-2:0], pull_low_o};
  end

  assign mask = pull_low_o || (|blank_q);

  sup_strobe_filt #(
    .MIN_CYC (STB_MIN_CYCLES)
  ) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .below_i (pin_sync[0]),
    .mask_i  (mask),
    .hit_o   (strobe_hit)
  );

  sup_override_deb #(
    .DEB_CYC (DEB_CYCLES)
  ) u_deb (
    .clk     (clk),
    .rst_n   (rst_n),
    .below_i (pin_sync[1]),
    .mask_i  (mask),
    .acc_o   (ovr_hit)
  );

  sup_fsm #(
    .RST_CYCLES (RST_CYCLES),
    .WDT_CYCLES (WDT_CYCLES)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok_i  (supply_ok_i),
    .strobe_hit_i (strobe_hit),
    .ovr_hit_i    (ovr_hit),
    .pull_low_o   (pull_low_o),
    .wd_trip_o    (wd_trip_o)
  );

  // R10: the cycle after the block lets go, no detector fires on the echo
  p_no_self_trigger_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_low_o) |=> (!ovr_hit && !strobe_hit));

  // R10: no detection while the block drives the line itself
  p_own_low_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low_o |-> (!ovr_hit && !strobe_hit));

endmodule

// File: tb/sim_rst_supervisor.sv
`timescale 1ns/1ps
module sim_rst_supervisor;

  localparam int RST = 20;
  localparam int WDT = 50;
  localparam int DEB = 4;
  localparam int STB = 3;
  localparam int OFS = 10;

  localparam int GAP_NONE = WDT;
  localparam int GAP_STB  = WDT + OFS + 2 + STB;
  localparam int GAP_OVR  = DEB + OFS + 2;

  // {on logic view, low width, expected low gap, expected status}
  localparam int NV = 9;
  localparam int VEC [NV][4] = '{
    '{0, 1, GAP_NONE, 1},
    '{0, 2, GAP_NONE, 1},
    '{0, 3, GAP_STB,  1},
    '{0, 8, GAP_STB,  1},
    '{1, 2, GAP_NONE, 1},
    '{1, 3, GAP_STB,  1},
    '{1, 4, GAP_OVR,  0},
    '{1, 8, GAP_OVR,  0},
    '{0, 0, GAP_NONE, 1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok;
  logic ext_drv;
  logic stb_drv;
  logic pull_low;
  logic wd_trip;
  logic below_strobe;
  logic below_logic;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  assign below_logic  = pull_low | ext_drv;
  assign below_strobe = pull_low | ext_drv | stb_drv;

  rst_supervisor #(
    .RST_CYCLES     (RST),
    .WDT_CYCLES     (WDT),
    .DEB_CYCLES     (DEB),
    .STB_MIN_CYCLES (STB),
    .SYNC_STAGES    (2)
  ) u0 (
    .clk                (clk),
    .rst_n              (rst_n),
    .supply_ok_i        (supply_ok),
    .pin_below_strobe_i (below_strobe),
    .pin_below_logic_i  (below_logic),
    .pull_low_o         (pull_low),
    .wd_trip_o          (wd_trip)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // starts on a negedge with the line released; returns on the next such negedge
  task automatic run_vec(input int on_logic, input int w,
                         output int gap, output int plen, output int wflag,
                         output int stat_leak);
    int  t    = 0;
    bit  seen = 1'b0;
    bit  done = 1'b0;
    gap = 0; plen = 0; wflag = 0; stat_leak = 0;
    while (!done && t < 4000) begin
      ext_drv = (on_logic != 0) && (t >= OFS) && (t < OFS + w);
      stb_drv = (on_logic == 0) && (t >= OFS) && (t < OFS + w);
      if (!seen) begin
        if (pull_low) begin
          seen  = 1'b1;
          wflag = wd_trip;
          plen  = 1;
        end else begin
          gap++;
          if (wd_trip) stat_leak = 1;
        end
      end else if (pull_low) begin
        plen++;
        if (wd_trip != wflag) stat_leak = 1;
      end else begin
        done = 1'b1;
      end
      if (!done) begin
        t++;
        @(negedge clk);
      end
    end
    ext_drv = 1'b0;
    stb_drv = 1'b0;
  endtask

  task automatic count_hold(output int c);
    c = 0;
    while (pull_low && c < 4000) begin
      c++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200_000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int c;
    int gap;
    int plen;
    int wf;
    int leak;
    rst_n     = 1'b0;
    supply_ok = 1'b0;
    ext_drv   = 1'b0;
    stb_drv   = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pull in reset", int'(pull_low), 1);
    chk("R12 status in reset", int'(wd_trip), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 pull with bad supply", int'(pull_low), 1);

    // R3: short supply drop during hold-off restarts the count
    supply_ok = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 still holding", int'(pull_low), 1);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    #1;
    @(negedge clk);
    count_hold(c);
    chk("R3 hold restarted", c + 1, RST);

    // table of lows at fixed offset after each release: R4 R5 R6 R7 R8 R9 R10 R12
    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i][0], VEC[i][1], gap, plen, wf, leak);
      chk($sformatf("R6 R7 R9 gap v%0d", i), gap, VEC[i][2]);
      chk($sformatf("R4 R8 pulse len v%0d", i), plen, RST);
      chk($sformatf("R12 status v%0d", i), wf, VEC[i][3]);
      chk($sformatf("R12 status steady v%0d", i), leak, 0);
    end

    // R5 R10: unserviced, next pulse after a full timeout, no self trigger
    c = 0;
    while (!pull_low && c < 4000) begin
      c++;
      @(negedge clk);
    end
    chk("R5 R10 repeat gap", c, WDT);
    repeat (3) @(negedge clk);
    chk("R12 status in wd pulse", int'(wd_trip), 1);

    // R1 R11: supply fails mid pulse
    supply_ok = 1'b0;
    #1;
    chk("R1 immediate pull", int'(pull_low), 1);
    @(negedge clk);
    chk("R11 status cleared", int'(wd_trip), 0);
    supply_ok = 1'b1;
    #1;
    @(negedge clk);
    count_hold(c);
    chk("R11 R2 full hold after failure", c + 1, RST);
    run_vec(0, 0, gap, plen, wf, leak);
    chk("R11 gap after hold", gap, WDT);
    chk("R4 pulse after hold", plen, RST);

    // R1: combinational pull while the line is released
    repeat (5) @(negedge clk);
    chk("R1 released before drop", int'(pull_low), 0);
    supply_ok = 1'b0;
    #1;
    chk("R1 pull without clock", int'(pull_low), 1);
    @(negedge clk);
    supply_ok = 1'b1;
    #1;
    count_hold(c);
    chk("R2 hold length", c, RST);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule